// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block is the reset controller of a small 8-bit microcontroller core. Three requests can start a reset: the external reset pin driven low, a one-cycle underflow pulse from the watchdog, and the output of a low-voltage detector. The detector output is formed here from two comparator flags with hysteresis. Every source leads into the same sequence. The sequencer holds reset while any request is present. It then counts a fixed settling delay, reads the two-byte reset vector from the top of program ROM over a plain combinational read port, and releases the core.

While it is in the sequence, the block keeps the core in reset and pulses a strobe that empties the hardware stack. It forces the core into non-maskable-interrupt mode, so that the start-up routine cannot be pre-empted. That mode lasts until the core reports a return-from-interrupt. On the first run cycle the program counter is loaded with the assembled vector. A status field keeps a record of which source caused the most recent reset.

The power-on reset `por_n` only initialises the block's own flops. The block reports it as cause code 2'b00.

Top module: `boot_reset_ctrl`

## Requirements
- R1: A watchdog underflow pulse seen in one cycle puts `core_rst` high from the next cycle on. The pin request and the low-voltage request also start the same sequence.
- R2: `ext_rst_n` passes through a two-flop synchronizer before it acts. After the pin is released, `core_rst` stays high for 2052 samples, counted from the first clock edge after the release.
- R3: Once no request is present, the sequencer spends exactly `DELAY_CYCLES` (default 2048) cycles in the delay phase. A watchdog-triggered reset therefore holds `core_rst` high for 1 + 2048 + 2 cycles.
- R4: The vector fetch lasts exactly two cycles, with `rom_rd` high. `rom_addr` is 0xFFE in the first cycle and 0xFFF in the second.
- R5: `pc_vector` = {byte at 0xFFF bits [3:0], byte at 0xFFE}. `pc_load` is high for exactly one cycle, which is the first cycle with `core_rst` low.
- R6: `stack_clr` is a one-cycle strobe in the first cycle of every reset hold phase.
- R7: `nmi_mode` is high whenever `core_rst` is high. It stays high in run mode until a cycle with `reti_exec` high and `core_rst` low, and it is low from the next cycle on. `reti_exec` has no effect while `core_rst` is high.
- R8: The low-voltage request is set by `lv_below_lo` and cleared only by `lv_above_hi`. With both flags low, the request keeps its last value.
- R9: A new request during the delay or fetch phase returns to hold and restarts the whole delay count.
- R10: `rst_cause` encodes the last source as 2'b01 for the pin, 2'b10 for the watchdog and 2'b11 for low voltage, and as 2'b00 after power-on. When sources coincide, low voltage wins over the watchdog, and the watchdog wins over the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset of the block, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| wdg_underflow | input | 1 | Watchdog underflow pulse |
| lv_below_lo | input | 1 | Supply below lower threshold |
| lv_above_hi | input | 1 | Supply above upper threshold |
| reti_exec | input | 1 | Core executes return-from-interrupt |
| rom_rdata | input | DATA_W | ROM read data, combinational from rom_addr |
| rom_rd | output | 1 | ROM read enable during vector fetch |
| rom_addr | output | ADDR_W | ROM read address |
| core_rst | output | 1 | Internal reset to the core, active high |
| stack_clr | output | 1 | Stack clear strobe |
| nmi_mode | output | 1 | Non-maskable-interrupt mode flag |
| pc_load | output | 1 | Program counter load strobe |
| pc_vector | output | ADDR_W | Reset vector for the program counter |
| rst_cause | output | 2 | Source of the most recent reset |

## Verification
The bench counts the exact number of reset cycles for each source, so a delay counter that is off by one, or a synchronizer with the wrong number of stages, shows up as a wrong length. It fires requests in the middle of the delay and in the first fetch cycle. A sequencer that resumes instead of restarting would release the core early. It holds both hysteresis flags low after a brown-out, where a plain comparator would release reset too soon. It also checks coinciding sources, where a wrong priority would report the watchdog instead of low voltage. Return-from-interrupt pulses are sent during reset, and a flag that obeyed them there would leave the core interruptible in its start-up code.

// File: rtl/boot_reset_pkg.sv
package boot_reset_pkg;

  typedef enum logic [2:0] {
    PH_HOLD   = 3'd0,
    PH_DELAY  = 3'd1,
    PH_FETCH0 = 3'd2,
    PH_FETCH1 = 3'd3,
    PH_RUN    = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    CAUSE_POR = 2'b00,
    CAUSE_PIN = 2'b01,
    CAUSE_WDG = 2'b10,
    CAUSE_LV  = 2'b11
  } cause_e;

  // Highest priority source among those active this cycle.
  function automatic cause_e pick_cause(input logic pin, input logic wdg,
                                        input logic lv, input cause_e prev);
    if (lv)       return CAUSE_LV;
    else if (wdg) return CAUSE_WDG;
    else if (pin) return CAUSE_PIN;
    else          return prev;
  endfunction

  // Hysteresis update: lower threshold sets, upper threshold clears.
  function automatic logic hyst_next(input logic below, input logic above,
                                     input logic held);
    if (below)      return 1'b1;
    else if (above) return 1'b0;
    else            return held;
  endfunction

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic pin_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], pin_n};
  end

  assign pin_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lv_hysteresis.sv
module lv_hysteresis
  import boot_reset_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic below_lo,
  input  logic above_hi,
  output logic lv_req
);
  logic held_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) held_q <= 1'b0;
    else        held_q <= hyst_next(below_lo, above_hi, held_q);
  end

  assign lv_req = held_q;
endmodule

// File: rtl/rst_phase_fsm.sv
module rst_phase_fsm
  import boot_reset_pkg::*;
#(
  parameter int DELAY_CYCLES = 2048
) (
  input  logic   clk,
  input  logic   por_n,
  input  logic   req_pin,
  input  logic   req_wdg,
  input  logic   req_lv,
  output phase_e phase,
  output cause_e cause
);
  localparam int CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY_CYCLES - 1);

  phase_e           phase_q, phase_d;
  cause_e           cause_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             any_req;

  assign any_req = req_pin | req_wdg | req_lv;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_HOLD: begin
        if (!any_req) begin
          phase_d = PH_DELAY;
          cnt_d   = '0;
        end
      end
      PH_DELAY: begin
        if (any_req)               phase_d = PH_HOLD;
        else if (cnt_q == CNT_LAST) phase_d = PH_FETCH0;
        else                       cnt_d   = cnt_q + 1'b1;
      end
      PH_FETCH0: phase_d = any_req ? PH_HOLD : PH_FETCH1;
      PH_FETCH1: phase_d = any_req ? PH_HOLD : PH_RUN;
      PH_RUN:    if (any_req) phase_d = PH_HOLD;
      default:   phase_d = PH_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase_q <= PH_HOLD;
      cnt_q   <= '0;
      cause_q <= CAUSE_POR;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (any_req) cause_q <= pick_cause(req_pin, req_wdg, req_lv, cause_q);
    end
  end

  assign phase = phase_q;
  assign cause = cause_q;
endmodule

// File: rtl/vec_fetch.sv
module vec_fetch
  import boot_reset_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  phase_e            phase,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [ADDR_W-1:0] pc_vector,
  output logic              pc_load
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] VEC_LO_ADDR = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] VEC_HI_ADDR = '1;

  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              was_fetch1_q;

  assign rom_rd   = (phase == PH_FETCH0) || (phase == PH_FETCH1);
  assign rom_addr = (phase == PH_FETCH1) ? VEC_HI_ADDR : VEC_LO_ADDR;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lo_q         <= '0;
      hi_q         <= '0;
      was_fetch1_q <= 1'b0;
    end else begin
      if (phase == PH_FETCH0) lo_q <= rom_rdata;
      if (phase == PH_FETCH1) hi_q <= rom_rdata[HI_W-1:0];
      was_fetch1_q <= (phase == PH_FETCH1);
    end
  end

  assign pc_vector = {hi_q, lo_q};
  assign pc_load   = (phase == PH_RUN) && was_fetch1_q;
endmodule

// File: rtl/boot_reset_ctrl.sv
module boot_reset_ctrl
  import boot_reset_pkg::*;
#(
  parameter int DELAY_CYCLES = 2048,
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic              wdg_underflow,
  input  logic              lv_below_lo,
  input  logic              lv_above_hi,
  input  logic              reti_exec,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              core_rst,
  output logic              stack_clr,
  output logic              nmi_mode,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_vector,
  output logic [1:0]        rst_cause
);
  // Named internal events, also used by the bound checker.
  logic   pin_n_sync, req_pin, req_lv, any_req;
  logic   delay_active, hold_active;
  logic   hold_seen_q, nmi_q;
  phase_e phase;
  cause_e cause;

  rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por_n(por_n), .pin_n(ext_rst_n), .pin_n_sync(pin_n_sync)
  );

  lv_hysteresis u_lv (
    .clk(clk), .por_n(por_n), .below_lo(lv_below_lo),
    .above_hi(lv_above_hi), .lv_req(req_lv)
  );

  assign req_pin = ~pin_n_sync;
  assign any_req = req_pin | wdg_underflow | req_lv;

  rst_phase_fsm #(.DELAY_CYCLES(DELAY_CYCLES)) u_fsm (
    .clk(clk), .por_n(por_n), .req_pin(req_pin), .req_wdg(wdg_underflow),
    .req_lv(req_lv), .phase(phase), .cause(cause)
  );

  vec_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk(clk), .por_n(por_n), .phase(phase), .rom_rdata(rom_rdata),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .pc_vector(pc_vector),
    .pc_load(pc_load)
  );

  assign delay_active = (phase == PH_DELAY);
  assign hold_active  = (phase == PH_HOLD);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hold_seen_q <= 1'b0;
      nmi_q       <= 1'b1;
    end else begin
      hold_seen_q <= hold_active;
      if (any_req || phase != PH_RUN) nmi_q <= 1'b1;
      else if (reti_exec)             nmi_q <= 1'b0;
    end
  end

  assign core_rst  = (phase != PH_RUN);
  assign stack_clr = hold_active & ~hold_seen_q;
  assign nmi_mode  = nmi_q;
  assign rst_cause = cause;
endmodule

// File: rtl/boot_reset_chk.sv
module boot_reset_chk #(
  parameter int DELAY_CYCLES = 2048,
  parameter int ADDR_W       = 12
) (
  input logic              clk,
  input logic              por_n,
  input logic              wdg_underflow,
  input logic              reti_exec,
  input logic              core_rst,
  input logic              stack_clr,
  input logic              nmi_mode,
  input logic              pc_load,
  input logic              rom_rd,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              delay_active,
  input logic              hold_active
);
  int dly_run_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            dly_run_q <= 0;
    else if (delay_active) dly_run_q <= dly_run_q + 1;
    else                   dly_run_q <= 0;
  end

  p_wdg_enters_reset_r1: assert property (@(posedge clk) disable iff (!por_n)
    wdg_underflow |=> (core_rst && hold_active));

  p_delay_length_r3: assert property (@(posedge clk) disable iff (!por_n)
    (rom_rd && !rom_addr[0]) |-> (dly_run_q == DELAY_CYCLES));

  p_fetch_addr_r4: assert property (@(posedge clk) disable iff (!por_n)
    rom_rd |-> (rom_addr[ADDR_W-1:1] == {(ADDR_W-1){1'b1}}));

  p_fetch_two_cycles_r4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pc_load) |-> ($past(rom_rd, 1) && $past(rom_rd, 2)));

  p_release_loads_pc_r5: assert property (@(posedge clk) disable iff (!por_n)
    $fell(core_rst) |-> pc_load);

  p_pc_load_single_r5: assert property (@(posedge clk) disable iff (!por_n)
    pc_load |=> !pc_load);

  p_stack_strobe_r6: assert property (@(posedge clk) disable iff (!por_n)
    stack_clr |=> !stack_clr);

  p_stack_on_entry_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst) |-> stack_clr);

  p_nmi_in_reset_r7: assert property (@(posedge clk) disable iff (!por_n)
    core_rst |-> nmi_mode);

  p_nmi_clear_cause_r7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(nmi_mode) |-> ($past(reti_exec) && !$past(core_rst)));
endmodule

bind boot_reset_ctrl boot_reset_chk #(
  .DELAY_CYCLES(DELAY_CYCLES), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .por_n(por_n), .wdg_underflow(wdg_underflow),
  .reti_exec(reti_exec), .core_rst(core_rst), .stack_clr(stack_clr),
  .nmi_mode(nmi_mode), .pc_load(pc_load), .rom_rd(rom_rd),
  .rom_addr(rom_addr), .delay_active(delay_active),
  .hold_active(hold_active)
);

// File: tb/boot_reset_ctrl_test.sv
`timescale 1ns/1ps
module boot_reset_ctrl_test;
  localparam int DLY = 2048;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, ext_rst_n = 1'b1, wdg_underflow = 1'b0;
  logic        lv_below_lo = 1'b0, lv_above_hi = 1'b0, reti_exec = 1'b0;
  logic [7:0]  rom_rdata;
  logic        rom_rd, core_rst, stack_clr, nmi_mode, pc_load;
  logic [11:0] rom_addr, pc_vector;
  logic [1:0]  rst_cause;

  logic [7:0]  vec_lo = 8'h34, vec_hi = 8'hE2;
  int          errors = 0, checks = 0, sc_cnt = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  boot_reset_ctrl uut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .wdg_underflow(wdg_underflow), .lv_below_lo(lv_below_lo),
    .lv_above_hi(lv_above_hi), .reti_exec(reti_exec), .rom_rdata(rom_rdata),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .core_rst(core_rst),
    .stack_clr(stack_clr), .nmi_mode(nmi_mode), .pc_load(pc_load),
    .pc_vector(pc_vector), .rst_cause(rst_cause)
  );

  // ROM model: vector bytes at the top, filler elsewhere.
  always_comb begin
    if (rom_addr == 12'hFFE)      rom_rdata = vec_lo;
    else if (rom_addr == 12'hFFF) rom_rdata = vec_hi;
    else                          rom_rdata = 8'hA5;
  end

  always @(negedge clk) if (por_n && stack_clr) sc_cnt++;

  // Expected reset lengths, counted from the first sample after the trigger edge.
  function automatic int exp_len(input int src);
    case (src)
      1:       return DLY + 4;   // pin: two sync stages plus hold
      0:       return DLY + 2;   // power-on release
      default: return DLY + 3;   // watchdog or low voltage
    endcase
  endfunction

  function automatic logic [11:0] exp_pc(input logic [7:0] lo, input logic [7:0] hi);
    return {hi[3:0], lo};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Count samples with core_rst high; check fetch order and the release cycle.
  task automatic count_reset(input string req, input int exp_n, input int reti_at);
    int n = 0;
    int nrd = 0;
    while (core_rst && n < 6000) begin
      if (rom_rd) begin
        check("R4 fetch address", rom_addr, (nrd == 0) ? 12'hFFE : 12'hFFF);
        nrd++;
      end
      reti_exec = (n == reti_at);
      n++;
      @(negedge clk);
    end
    reti_exec = 1'b0;
    check({req, " reset length"}, n, exp_n);
    check("R4 fetch cycles", nrd, 2);
    check("R5 pc_load on first run cycle", pc_load, 1'b1);
    check("R5 pc_vector", pc_vector, exp_pc(vec_lo, vec_hi));
    check("R7 nmi_mode after reset", nmi_mode, 1'b1);
    @(negedge clk);
    check("R5 pc_load single cycle", pc_load, 1'b0);
  endtask

  task automatic wdg_pulse();
    wdg_underflow = 1'b1;
    @(negedge clk);
    wdg_underflow = 1'b0;
  endtask

  task automatic run_source(input int src, input int pin_len);
    case (src)
      1: begin
        ext_rst_n = 1'b0;
        repeat (pin_len) @(negedge clk);
        check("R2 core_rst while pin low", core_rst, 1'b1);
        ext_rst_n = 1'b1;
        @(negedge clk);
        count_reset("R2", exp_len(1), -1);
        check("R10 cause pin", rst_cause, 2'b01);
      end
      2: begin
        wdg_pulse();
        count_reset("R1 R3", exp_len(2), -1);
        check("R10 cause watchdog", rst_cause, 2'b10);
      end
      default: begin
        lv_below_lo = 1'b1;
        @(negedge clk);
        lv_below_lo = 1'b0;
        repeat (pin_len) @(negedge clk);
        check("R8 held with both flags low", core_rst, 1'b1);
        lv_above_hi = 1'b1;
        @(negedge clk);
        lv_above_hi = 1'b0;
        count_reset("R8", exp_len(3), -1);
        check("R10 cause low voltage", rst_cause, 2'b11);
      end
    endcase
  endtask

  initial begin
    int s0;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    check("R1 core_rst in power-on", core_rst, 1'b1);
    check("R7 nmi_mode in power-on", nmi_mode, 1'b1);
    check("R4 no rom read in power-on", rom_rd, 1'b0);
    por_n = 1'b1;
    @(negedge clk);
    // reti pulsed mid-reset must be ignored (R7)
    count_reset("R3 power-on", exp_len(0), 100);
    check("R10 cause after power-on", rst_cause, 2'b00);

    reti_exec = 1'b1;
    @(negedge clk);
    reti_exec = 1'b0;
    check("R7 reti clears nmi_mode", nmi_mode, 1'b0);

    // Watchdog, with stack strobe count (R6).
    s0 = sc_cnt;
    run_source(2, 0);
    check("R6 one stack_clr per reset", sc_cnt - s0, 1);
    run_source(1, 10);
    run_source(3, 50);

    // R9: restart during the delay.
    s0 = sc_cnt;
    wdg_pulse();
    repeat (700) @(negedge clk);
    wdg_pulse();
    count_reset("R9 restart in delay", exp_len(2), -1);
    check("R6 stack_clr per restart", sc_cnt - s0, 2);

    // R9: restart in the first fetch cycle.
    wdg_pulse();
    while (!rom_rd) @(negedge clk);
    wdg_pulse();
    count_reset("R9 restart in fetch", exp_len(2), -1);

    // R10: coinciding watchdog and low voltage, low voltage wins.
    wdg_underflow = 1'b1;
    lv_below_lo   = 1'b1;
    @(negedge clk);
    wdg_underflow = 1'b0;
    lv_below_lo   = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 priority low voltage", rst_cause, 2'b11);
    lv_above_hi = 1'b1;
    @(negedge clk);
    lv_above_hi = 1'b0;
    count_reset("R10 priority", exp_len(3), -1);

    // Random sources and vectors.
    for (int i = 0; i < 8; i++) begin
      int src = 1 + ($urandom % 3);
      vec_lo = 8'($urandom);
      vec_hi = 8'($urandom);
      run_source(src, 3 + ($urandom % 30));
      reti_exec = 1'b1;
      @(negedge clk);
      reti_exec = 1'b0;
      check("R7 reti in run", nmi_mode, 1'b0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule